// File: doc/BRIEF.md
# Serial Real-Time Clock Register Slave

This block is the device side of a three-wire serial link (chip enable, serial clock, one shared data line). It holds a calendar and time-of-day register file in BCD, a control register carrying a write-protect flag, and a small scratch RAM. A transaction begins when chip enable rises. The master then clocks in a command byte, least significant bit first. The slave decodes the command and either accepts data bytes or returns register contents, one register at a time or as an eight-byte clock sequence.

A one-second tick input advances the time registers through seconds, minutes, hours, date, month and year. Month lengths and leap years follow the year register. A halt flag in the seconds register freezes the count. The serial inputs pass through a two-stage synchronizer into the block's clock domain, and every link event is detected on that clock.

Top module: `rtc_slave`

## Requirements
- R1: A command byte is bit 7 = 1, bits 6:1 = address, bit 0 = 1 for read or 0 for write, sent least significant bit first. A command with bit 7 clear makes the rest of that transaction ignored: nothing is written and the data line is never driven.
- R2: The slave samples `sio_in` on rising `sclk`. For a read, it launches data least significant bit first on falling `sclk`, starting at the fall after the eighth command rise. `sio_oe` is high only during that read phase and is low after reset.
- R3: The register map is seconds 0x00 (8 bits, bit 7 = halt), minutes 0x01 (7 bits), hours 0x02 (6 bits, 24-hour), date 0x03 (6 bits), month 0x04 (5 bits), day of week 0x05 (3 bits), year 0x06 (8 bits) and control 0x07. Bits above the stated width read back as 0. After reset the registers hold 00,00,00,01,01,01,00 and control is 0x80.
- R4: Address 0x1F (command 0xBE to write, 0xBF to read) transfers eight bytes in address order 0x00 to 0x07, ending with the control register.
- R5: Control bit 7 is write protect, set by reset. While it is set, writes to every address except control are refused. Control is always writable, and its bits 6:0 read as 0.
- R6: While seconds bit 7 is set, ticks leave all time registers unchanged.
- R7: Each tick with the halt flag clear advances seconds. Seconds 59 goes to 00 and carries into minutes, minutes 59 to 00 carries into hours, and hours 23 to 00 carries into the day.
- R8: A day carry steps day of week (7 to 1) and date. The date rolls over to 01 after the last day of the month: 30 or 31 days, February 29 when the year is divisible by 4 (00 included), otherwise 28. That rollover steps the month, and month 12 to 01 steps the year, which goes from 99 to 00.
- R9: Chip enable low ends a transaction at once. The data line is released within 4 clock cycles. A read stopped early changes nothing, and bytes already written in a stopped multi-byte write are kept.
- R10: A data byte commits on the third `clk` rising edge after `sclk` rises for its last bit. A tick sampled on the same edge as a time-register commit is applied one cycle later, on top of the written value.
- R11: The scratch RAM covers 0x20 up to 0x20+RAM_BYTES-1 (0x3E by default). Reads of any other address, 0x08 included, return 0x00, and writes to such addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1s | input | 1 | One-cycle pulse per second |
| ce | input | 1 | Link chip enable, active high |
| sclk | input | 1 | Link serial clock |
| sio_in | input | 1 | Data line as seen at the pad |
| sio_out | output | 1 | Data value to drive during reads |
| sio_oe | output | 1 | Drive enable for the data line |

## Verification
The seconds tick and a register commit arriving from the link can land on the same clock edge. That collision decides whether a tick is lost, applied to the old value, or applied on top of the new one. The bench writes the seconds register three times and places the tick pulse one cycle before, exactly on, and one cycle after the commit edge. It then reads the register back: the earlier tick must be overwritten, while the coincident and the later tick must both add one to the written value.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam logic [5:0] CTRL_ADDR  = 6'h07;
  localparam logic [5:0] YEAR_ADDR  = 6'h06;
  localparam logic [5:0] BURST_ADDR = 6'h1F;
  localparam logic [5:0] RAM_BASE   = 6'h20;
  localparam int         BURST_LEN  = 8;

  typedef enum logic [1:0] {PH_CMD, PH_WR, PH_RD, PH_END} link_phase_e;

  typedef struct packed {
    logic [7:0] year;
    logic [7:0] dow;
    logic [7:0] mon;
    logic [7:0] date;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } rtc_time_t;

  localparam rtc_time_t TIME_AT_RESET = '{year: 8'h00, dow: 8'h01, mon: 8'h01,
                                          date: 8'h01, hour: 8'h00, min: 8'h00,
                                          sec: 8'h00};

  // BCD increment of a two-digit value
  function automatic logic [7:0] bcd_step(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  // {carry, next}: wraps to 'first' once 'last' is reached or passed
  function automatic logic [8:0] wrap_step(input logic [7:0] v, input logic [7:0] last,
                                           input logic [7:0] first);
    if (v >= last) return {1'b1, first};
    return {1'b0, bcd_step(v)};
  endfunction

  // leap test on a BCD year: divisible by 4
  function automatic logic leap_bcd(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return leap_bcd(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic rtc_time_t rtc_advance(input rtc_time_t t);
    rtc_time_t  n;
    logic [8:0] r;
    logic [8:0] d;
    n = t;
    r = wrap_step({1'b0, t.sec[6:0]}, 8'h59, 8'h00);
    n.sec = {t.sec[7], r[6:0]};
    if (r[8]) begin
      r = wrap_step(t.min, 8'h59, 8'h00);
      n.min = r[7:0];
      if (r[8]) begin
        r = wrap_step(t.hour, 8'h23, 8'h00);
        n.hour = r[7:0];
        if (r[8]) begin
          d = wrap_step(t.dow, 8'h07, 8'h01);
          n.dow = d[7:0];
          r = wrap_step(t.date, month_last(t.mon, t.year), 8'h01);
          n.date = r[7:0];
          if (r[8]) begin
            r = wrap_step(t.mon, 8'h12, 8'h01);
            n.mon = r[7:0];
            if (r[8]) begin
              r = wrap_step(t.year, 8'h99, 8'h00);
              n.year = r[7:0];
            end
          end
        end
      end
    end
    return n;
  endfunction

endpackage

// File: rtl/rtc_link.sv
module rtc_link
  import rtc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce,
  input  logic       sclk,
  input  logic       sio_in,
  output logic       sio_out,
  output logic       sio_oe,
  output logic       wr_stb,
  output logic [5:0] wr_addr,
  output logic [7:0] wr_data,
  output logic [5:0] rd_addr,
  input  logic [7:0] rd_data
);
  localparam int CNT_W = $clog2(BURST_LEN + 1);

  logic [SYNC_STAGES-1:0] ce_sh, sclk_sh, io_sh;
  logic s_ce, s_sclk, s_io, sclk_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_sh   <= '0;
      sclk_sh <= '0;
      io_sh   <= '0;
    end else begin
      ce_sh   <= {ce_sh[SYNC_STAGES-2:0], ce};
      sclk_sh <= {sclk_sh[SYNC_STAGES-2:0], sclk};
      io_sh   <= {io_sh[SYNC_STAGES-2:0], sio_in};
    end
  end
  assign s_ce   = ce_sh[SYNC_STAGES-1];
  assign s_sclk = sclk_sh[SYNC_STAGES-1];
  assign s_io   = io_sh[SYNC_STAGES-1];

  // named link events
  logic rise_w, fall_w, byte_done;
  assign rise_w = s_ce && s_sclk && !sclk_d;
  assign fall_w = s_ce && !s_sclk && sclk_d;

  link_phase_e      ph_q;
  logic [7:0]       sh_q, tx_q;
  logic [2:0]       bit_q, rbit_q;
  logic             burst_q, out_q, oe_q;
  logic [5:0]       ptr_q;
  logic [CNT_W-1:0] cnt_q, rlimit;
  logic [7:0]       byte_w;

  assign byte_w    = {s_io, sh_q[7:1]};
  assign byte_done = rise_w && (bit_q == 3'd7);
  assign rlimit    = burst_q ? CNT_W'(BURST_LEN) : CNT_W'(1);

  assign wr_stb  = byte_done && (ph_q == PH_WR);
  assign wr_addr = ptr_q;
  assign wr_data = byte_w;
  assign rd_addr = ptr_q;
  assign sio_out = out_q;
  assign sio_oe  = oe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_d  <= 1'b0;
      ph_q    <= PH_CMD;
      sh_q    <= '0;
      tx_q    <= '0;
      bit_q   <= '0;
      rbit_q  <= '0;
      burst_q <= 1'b0;
      out_q   <= 1'b0;
      oe_q    <= 1'b0;
      ptr_q   <= '0;
      cnt_q   <= '0;
    end else begin
      sclk_d <= s_sclk;
      if (!s_ce) begin
        ph_q    <= PH_CMD;
        bit_q   <= '0;
        rbit_q  <= '0;
        cnt_q   <= '0;
        burst_q <= 1'b0;
        oe_q    <= 1'b0;
        out_q   <= 1'b0;
        ptr_q   <= '0;
      end else begin
        if (rise_w && (ph_q == PH_CMD || ph_q == PH_WR)) begin
          sh_q  <= byte_w;
          bit_q <= bit_q + 3'd1;
        end
        if (byte_done && ph_q == PH_CMD) begin
          if (!byte_w[7]) begin
            ph_q <= PH_END;                       // R1: malformed command
          end else begin
            ph_q    <= byte_w[0] ? PH_RD : PH_WR;
            burst_q <= (byte_w[6:1] == BURST_ADDR);
            ptr_q   <= (byte_w[6:1] == BURST_ADDR) ? 6'd0 : byte_w[6:1];
          end
        end
        if (wr_stb) begin
          ptr_q <= ptr_q + 6'd1;
          cnt_q <= cnt_q + CNT_W'(1);
          if (!burst_q || cnt_q == CNT_W'(BURST_LEN - 1)) ph_q <= PH_END;
        end
        if (fall_w && ph_q == PH_RD) begin
          if (rbit_q == 3'd0) begin
            if (cnt_q < rlimit) begin
              out_q  <= rd_data[0];
              tx_q   <= {1'b0, rd_data[7:1]};
              oe_q   <= 1'b1;
              rbit_q <= 3'd1;
            end else begin
              oe_q <= 1'b0;
              ph_q <= PH_END;
            end
          end else begin
            out_q  <= tx_q[0];
            tx_q   <= {1'b0, tx_q[7:1]};
            rbit_q <= rbit_q + 3'd1;
            if (rbit_q == 3'd7) begin
              cnt_q <= cnt_q + CNT_W'(1);
              ptr_q <= ptr_q + 6'd1;
            end
          end
        end
      end
    end
  end

  // R9: chip enable low forces the line released on the next edge
  a_r9_release_on_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !s_ce |=> !oe_q);
  // R2: drive only begins at a falling serial clock
  a_r2_drive_starts_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> $past(fall_w));
  // R2: no drive while the command byte is still arriving
  a_r2_quiet_in_command: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_CMD) |-> !oe_q);
  // R4: multi-byte transfers stay within addresses 0x00..0x07
  a_r4_burst_window: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && burst_q) |-> (wr_addr < 6'(BURST_LEN)));

endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
#(
  parameter int RAM_BYTES = 31
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1s,
  input  logic       wr_stb,
  input  logic [5:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [5:0] rd_addr,
  output logic [7:0] rd_data
);
  localparam int RIW = (RAM_BYTES > 1) ? $clog2(RAM_BYTES) : 1;
  localparam logic [6:0] RAM_END = 7'(RAM_BASE) + 7'(RAM_BYTES);

  rtc_time_t t_q, t_nx;
  logic      wp_q, pend_q;

  // named internal events
  logic wr_ok, time_wr, halted, tick_go, adv;
  assign wr_ok   = wr_stb && (wr_addr == CTRL_ADDR || !wp_q);
  assign time_wr = wr_ok && (wr_addr <= YEAR_ADDR);
  assign halted  = t_q.sec[7];
  assign tick_go = (tick_1s || pend_q) && !halted;
  assign adv     = tick_go && !time_wr;

  always_comb begin
    t_nx = adv ? rtc_advance(t_q) : t_q;
    if (time_wr) begin
      case (wr_addr)
        6'h00:   t_nx.sec  = wr_data;
        6'h01:   t_nx.min  = {1'b0, wr_data[6:0]};
        6'h02:   t_nx.hour = {2'b0, wr_data[5:0]};
        6'h03:   t_nx.date = {2'b0, wr_data[5:0]};
        6'h04:   t_nx.mon  = {3'b0, wr_data[4:0]};
        6'h05:   t_nx.dow  = {5'b0, wr_data[2:0]};
        default: t_nx.year = wr_data;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_q    <= TIME_AT_RESET;
      wp_q   <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      t_q    <= t_nx;
      pend_q <= tick_go && time_wr;
      if (wr_ok && wr_addr == CTRL_ADDR) wp_q <= wr_data[7];
    end
  end

  logic [7:0] ram_rd [RAM_BYTES];
  for (genvar gi = 0; gi < RAM_BYTES; gi++) begin : g_cell
    logic [7:0] cell_q;
    always_ff @(posedge clk) begin
      if (!rst_n) cell_q <= '0;
      else if (wr_ok && wr_addr == RAM_BASE + 6'(gi)) cell_q <= wr_data;
    end
    assign ram_rd[gi] = cell_q;
  end

  logic           in_ram;
  logic [RIW-1:0] ridx;
  logic [5:0]     roff;
  assign in_ram = (rd_addr >= RAM_BASE) && ({1'b0, rd_addr} < RAM_END);
  assign roff   = rd_addr - RAM_BASE;
  assign ridx   = roff[RIW-1:0];

  always_comb begin
    case (rd_addr)
      6'h00:   rd_data = t_q.sec;
      6'h01:   rd_data = t_q.min;
      6'h02:   rd_data = t_q.hour;
      6'h03:   rd_data = t_q.date;
      6'h04:   rd_data = t_q.mon;
      6'h05:   rd_data = t_q.dow;
      6'h06:   rd_data = t_q.year;
      6'h07:   rd_data = {wp_q, 7'b0};
      default: rd_data = in_ram ? ram_rd[ridx] : 8'h00;
    endcase
  end

  // R6: a halted clock keeps every time field
  a_r6_halt_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !time_wr) |=> (t_q == $past(t_q)));
  // R5: protected RAM write leaves the first cell untouched
  a_r5_wp_blocks_ram: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wp_q && wr_addr == RAM_BASE) |=> (ram_rd[0] == $past(ram_rd[0])));
  // R7: seconds wrap from 59 to 00
  a_r7_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && t_q.sec[6:0] == 7'h59) |=> (t_q.sec[6:0] == 7'h00));
  // R10: a coincident tick is carried into the following cycle
  a_r10_tick_deferred: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_go && time_wr && wr_addr == 6'h00 && !wr_data[7] && wr_data[3:0] < 4'd9)
      |=> ##1 (t_q.sec == bcd_step($past(wr_data, 2))));

endmodule

// File: rtl/rtc_slave.sv
module rtc_slave #(
  parameter int RAM_BYTES   = 31,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_1s,
  input  logic ce,
  input  logic sclk,
  input  logic sio_in,
  output logic sio_out,
  output logic sio_oe
);
  logic       wr_stb;
  logic [5:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;

  rtc_link #(.SYNC_STAGES(SYNC_STAGES)) u_link (
    .clk(clk), .rst_n(rst_n), .ce(ce), .sclk(sclk), .sio_in(sio_in),
    .sio_out(sio_out), .sio_oe(sio_oe), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  rtc_regs #(.RAM_BYTES(RAM_BYTES)) u_regs (
    .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

endmodule

// File: tb/rtc_slave_tb.sv
module rtc_slave_tb;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0, tick_1s = 1'b0, ce = 1'b0, sclk = 1'b0, sio_m = 1'b0;
  logic sio_out, sio_oe;
  int   n_cmp = 0, n_bad = 0;
  logic oe_any, oe_all;
  logic [7:0] m [8];
  logic [7:0] rb [8];
  logic [7:0] v;

  always #4 clk = ~clk;

  rtc_slave u_dut (.clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .ce(ce), .sclk(sclk),
                   .sio_in(sio_m), .sio_out(sio_out), .sio_oe(sio_oe));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic int b2i(input logic [7:0] b); return b[7:4] * 10 + b[3:0]; endfunction
  function automatic logic [7:0] i2b(input int n); return 8'((n / 10) * 16 + n % 10); endfunction
  function automatic int dim(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  // expected-state model
  task automatic model_tick();
    int s, mi, h, d, mo, y, w;
    if (m[0][7]) return;
    s = b2i({1'b0, m[0][6:0]}); mi = b2i(m[1]); h = b2i(m[2]); d = b2i(m[3]);
    mo = b2i(m[4]); y = b2i(m[6]); w = m[5];
    s++;
    if (s == 60) begin
      s = 0; mi++;
      if (mi == 60) begin
        mi = 0; h++;
        if (h == 24) begin
          h = 0; w = (w == 7) ? 1 : w + 1; d++;
          if (d > dim(mo, y)) begin
            d = 1; mo++;
            if (mo == 13) begin mo = 1; y = (y + 1) % 100; end
          end
        end
      end
    end
    m[0] = i2b(s); m[1] = i2b(mi); m[2] = i2b(h); m[3] = i2b(d);
    m[4] = i2b(mo); m[5] = 8'(w); m[6] = i2b(y);
  endtask

  task automatic model_write(input logic [5:0] a, input logic [7:0] d);
    if (a != 6'h07 && m[7][7]) return;
    case (a)
      6'h00: m[0] = d;
      6'h01: m[1] = {1'b0, d[6:0]};
      6'h02: m[2] = {2'b0, d[5:0]};
      6'h03: m[3] = {2'b0, d[5:0]};
      6'h04: m[4] = {3'b0, d[4:0]};
      6'h05: m[5] = {5'b0, d[2:0]};
      6'h06: m[6] = d;
      6'h07: m[7] = {d[7], 7'b0};
      default: ;
    endcase
  endtask

  task automatic wait_n(input int n); repeat (n) @(negedge clk); endtask

  task automatic begin_x(); ce = 1'b1; sclk = 1'b0; wait_n(4); endtask
  task automatic end_x(); sclk = 1'b0; wait_n(2); ce = 1'b0; wait_n(6); endtask

  task automatic put_bit(input logic b, input int toff);
    sio_m = b; wait_n(HALF);
    sclk = 1'b1;
    if (toff > 0) begin
      wait_n(toff); tick_1s = 1'b1; wait_n(1); tick_1s = 1'b0; wait_n(HALF - toff - 1);
    end else wait_n(HALF);
    sclk = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] b, input int toff);
    for (int i = 0; i < 8; i++) put_bit(b[i], (i == 7) ? toff : 0);
  endtask

  task automatic get_byte(output logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      wait_n(HALF);
      b[i] = sio_out;
      oe_any = oe_any | sio_oe;
      oe_all = oe_all & sio_oe;
      sclk = 1'b1; wait_n(HALF); sclk = 1'b0;
    end
  endtask

  task automatic rd1(input logic [5:0] a, output logic [7:0] d);
    begin_x(); put_byte({1'b1, a, 1'b1}, 0); get_byte(d); end_x();
  endtask

  task automatic wr1(input logic [5:0] a, input logic [7:0] d, input int toff);
    begin_x(); put_byte({1'b1, a, 1'b0}, 0); put_byte(d, toff); end_x();
    model_write(a, d);
  endtask

  task automatic wr_all(input logic [7:0] b0, b1, b2, b3, b4, b5, b6, b7);
    logic [7:0] q [8];
    q[0] = b0; q[1] = b1; q[2] = b2; q[3] = b3; q[4] = b4; q[5] = b5; q[6] = b6; q[7] = b7;
    begin_x(); put_byte(8'hBE, 0);
    for (int i = 0; i < 8; i++) begin put_byte(q[i], 0); model_write(6'(i), q[i]); end
    end_x();
  endtask

  task automatic rd_all();
    begin_x(); put_byte(8'hBF, 0);
    for (int i = 0; i < 8; i++) get_byte(rb[i]);
    end_x();
  endtask

  task automatic cmp_all(input string tag);
    rd_all();
    for (int i = 0; i < 8; i++) chk(tag, rb[i], m[i]);
  endtask

  task automatic do_tick();
    tick_1s = 1'b1; wait_n(1); tick_1s = 1'b0; wait_n(1);
    model_tick();
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1977));
    m[0] = 8'h00; m[1] = 8'h00; m[2] = 8'h00; m[3] = 8'h01;
    m[4] = 8'h01; m[5] = 8'h01; m[6] = 8'h00; m[7] = 8'h80;
    wait_n(5); rst_n = 1'b1; wait_n(3);

    // R2/R3/R5/R4: reset values through a full multi-byte read
    chk("R2 oe after reset", {7'b0, sio_oe}, 8'h00);
    oe_all = 1'b1;
    cmp_all("R3 R4 reset map");
    chk("R2 oe during read", {7'b0, oe_all}, 8'h01);

    // R5: refused while protected
    wr1(6'h00, 8'h33, 0); rd1(6'h00, v); chk("R5 protected sec", v, 8'h00);
    wr1(6'h20, 8'h77, 0); rd1(6'h20, v); chk("R5 protected ram", v, 8'h00);
    wr1(6'h07, 8'h7F, 0); rd1(6'h07, v); chk("R5 ctrl low bits zero", v, 8'h00);

    // R11: RAM and unmapped
    wr1(6'h20, 8'hA5, 0); wr1(6'h3E, 8'h5A, 0);
    rd1(6'h20, v); chk("R11 ram first", v, 8'hA5);
    rd1(6'h3E, v); chk("R11 ram last", v, 8'h5A);
    wr1(6'h08, 8'hFF, 0); rd1(6'h08, v); chk("R11 unmapped 0x08", v, 8'h00);
    wr1(6'h3F, 8'hFF, 0); rd1(6'h3F, v); chk("R11 unmapped 0x3F", v, 8'h00);

    // R1: bit 7 clear commands are ignored
    begin_x(); put_byte(8'h40, 0); put_byte(8'h99, 0); end_x();
    rd1(6'h20, v); chk("R1 malformed write ignored", v, 8'hA5);
    oe_any = 1'b0;
    begin_x(); put_byte(8'h41, 0); get_byte(v); end_x();
    chk("R1 malformed read never drives", {7'b0, oe_any}, 8'h00);

    // R3: field masks
    wr1(6'h02, 8'hFF, 0); rd1(6'h02, v); chk("R3 hour mask", v, 8'h3F);
    wr1(6'h05, 8'hFF, 0); rd1(6'h05, v); chk("R3 dow mask", v, 8'h07);

    // R6: halt
    wr_all(8'h92, 8'h10, 8'h05, 8'h14, 8'h06, 8'h03, 8'h21, 8'h00);
    do_tick(); do_tick(); do_tick();
    rd1(6'h00, v); chk("R6 halted sec", v, 8'h92);
    wr1(6'h00, 8'h12, 0); do_tick();
    rd1(6'h00, v); chk("R6 resumed sec", v, 8'h13);

    // R7/R8: directed carries
    wr_all(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h07, 8'h24, 8'h00); do_tick();
    cmp_all("R7 R8 leap 2024");
    chk("R8 leap date", rb[3], 8'h29); chk("R8 dow wrap", rb[5], 8'h01);
    wr_all(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h03, 8'h23, 8'h00); do_tick();
    rd_all(); chk("R8 non-leap date", rb[3], 8'h01); chk("R8 non-leap month", rb[4], 8'h03);
    wr_all(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h03, 8'h00, 8'h00); do_tick();
    rd_all(); chk("R8 year 00 leap", rb[3], 8'h29);
    wr_all(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h02, 8'h51, 8'h00); do_tick();
    rd_all(); chk("R8 30-day month", rb[4], 8'h05);
    wr_all(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h05, 8'h99, 8'h00); do_tick();
    cmp_all("R8 year wrap");
    chk("R8 year 99->00", rb[6], 8'h00); chk("R7 hour wrap", rb[2], 8'h00);

    // R9: stopped transfers
    wr_all(8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h00);
    begin_x(); put_byte(8'hBE, 0); put_byte(8'h45, 0); put_byte(8'h12, 0); end_x();
    model_write(6'h00, 8'h45); model_write(6'h01, 8'h12);
    cmp_all("R9 partial write kept");
    begin_x(); put_byte(8'hBF, 0); get_byte(v); get_byte(v); get_byte(v);
    sclk = 1'b0; wait_n(2); ce = 1'b0; wait_n(4);
    chk("R9 line released", {7'b0, sio_oe}, 8'h00);
    wait_n(2);
    cmp_all("R9 stopped read no effect");

    // R10: tick against commit edge
    wr1(6'h00, 8'h10, 1); rd1(6'h00, v); chk("R10 tick before commit", v, 8'h10);
    wr1(6'h00, 8'h20, 2); rd1(6'h00, v); chk("R10 tick on commit", v, 8'h21);
    wr1(6'h00, 8'h30, 3); rd1(6'h00, v); chk("R10 tick after commit", v, 8'h31);
    m[0] = 8'h31;

    // random mix (R4 R7 R8)
    for (int it = 0; it < 28; it++) begin
      int yr, mo, dd, hh, mi, ss, k;
      yr = $urandom_range(0, 99); mo = $urandom_range(1, 12);
      dd = $urandom_range(1, dim(mo, yr)); hh = $urandom_range(0, 23);
      mi = $urandom_range(0, 59); ss = $urandom_range(0, 59);
      if ($urandom_range(0, 2) == 0) begin ss = 59; mi = 59; hh = 23; dd = dim(mo, yr); end
      wr_all(i2b(ss), i2b(mi), i2b(hh), i2b(dd), i2b(mo), 8'($urandom_range(1, 7)),
             i2b(yr), 8'h00);
      k = $urandom_range(0, 2);
      for (int j = 0; j < k; j++) do_tick();
      cmp_all("R4 R7 R8 random");
    end

    // R5: protection restored via control
    wr1(6'h07, 8'h80, 0); wr1(6'h20, 8'h11, 0);
    rd1(6'h20, v); chk("R5 re-protected ram", v, 8'hA5);
    rd1(6'h07, v); chk("R5 ctrl protected", v, 8'h80);

    finish_run();
  end
endmodule